// File: doc/BRIEF.md
# Tone Presence Guard Time Validator

This block qualifies a raw "tone present now" indication before anything downstream acts on it. The raw input comes from a tone detector and may chatter. The block produces a validated steering level that rises only after the raw input has held high for a full presence guard time. Once the level is high, it falls only after the raw input has stayed low for a full absence guard time. A short dropout in the middle of a tone is therefore bridged, and a short burst never reaches the output. Each guard time is a parameter counted in cycles of the system clock. The defaults assume a 4.194304 MHz clock, with about 40 ms for presence and 20 ms for absence.

The raw input passes through a configurable synchronizer chain. A four-state controller then handles qualification, using one shared down-counter that is reloaded on every state entry. A power-down input clears the output at once, and on the next clock edge it forces the controller back to idle. A one-cycle strobe marks each fresh validation, so that a downstream digit readout can re-arm on it.

Top module: `tone_guard_validator`

## Requirements
- R1: While reset is asserted (asynchronous, active low), `steer_o` and `rise_stb_o` are 0.
- R2: With `pwrdn_i` low, if `est_i` is sampled high on SYNC_STAGES+PRESENT_CYCLES consecutive rising clock edges starting from idle, `steer_o` becomes 1 right after the last of those edges and not before.
- R3: If `est_i` goes low before the presence count completes, `steer_o` stays 0 and qualification restarts from zero on the next high sample.
- R4: Once `steer_o` is 1, it becomes 0 right after `est_i` has been sampled low on SYNC_STAGES+ABSENT_CYCLES consecutive edges.
- R5: A low run on `est_i` that is shorter than the absence count leaves `steer_o` at 1, and the absence count restarts on the next low run.
- R6: While `pwrdn_i` is 1, `steer_o` is 0 in the same cycle (combinationally), and every clock edge returns the controller to idle with the counter cleared.
- R7: After `pwrdn_i` falls with `est_i` held high, `steer_o` rises after exactly PRESENT_CYCLES further edges. Presence qualification starts from zero.
- R8: `rise_stb_o` is 1 for exactly one cycle, in the cycle in which `steer_o` rises from a completed presence qualification. It stays 0 when the output is kept high across a bridged dropout.
- R9: PRESENT_CYCLES and ABSENT_CYCLES must each be at least 2. The shared counter never holds a value above the larger reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| est_i | input | 1 | Raw early tone-present indication |
| pwrdn_i | input | 1 | Power-down; forces output low and controller idle |
| steer_o | output | 1 | Validated, delayed steering level |
| rise_stb_o | output | 1 | One-cycle strobe on each validated rise |

## Verification
The bench probes both guard windows one edge short of completion and then at completion. An off-by-one counter would show up there as an early or late transition on `steer_o`. It sends a burst that is too short, followed by a single low sample and a new burst. A design that kept its count across the gap would then validate too early. It also bridges a dropout and samples the strobe just after the controller returns to the held state, where a strobe tied to any entry into that state would fire by mistake. Finally, power-down is applied during the held state, during absence qualification and during presence qualification. The output must drop in the same cycle, and presence must re-qualify from zero afterwards.

// File: rtl/tgv_pkg.sv
`timescale 1ns/1ps
package tgv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_QUAL_ON  = 2'd1,
      ST_HELD     = 2'd2,
      ST_QUAL_OFF = 2'd3
   } guard_state_e;

   function automatic int unsigned bits_for(input int unsigned value);
      return (value < 2) ? 1 : $clog2(value);
   endfunction

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tgv_sync.sv
`timescale 1ns/1ps
module tgv_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) begin
            chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tgv_down_counter.sv
`timescale 1ns/1ps
module tgv_down_counter #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_val_i,
   input  logic             dec_i,
   output logic [WIDTH-1:0] cnt_o,
   output logic             zero_o
);

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (dec_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - WIDTH'(1);
      end
   end

   assign cnt_o  = cnt_q;
   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/tgv_guard_fsm.sv
`timescale 1ns/1ps
module tgv_guard_fsm
   import tgv_pkg::*;
#(
   parameter int unsigned          WIDTH      = 8,
   parameter logic [WIDTH-1:0]     ON_RELOAD  = '0,
   parameter logic [WIDTH-1:0]     OFF_RELOAD = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pwrdn_i,
   input  logic             est_i,
   input  logic             cnt_zero_i,
   output logic             clr_o,
   output logic             load_o,
   output logic [WIDTH-1:0] load_val_o,
   output logic             dec_o,
   output logic             held_o,
   output logic             rise_o
);

   guard_state_e state_q, state_d;
   logic         rise_q;

   always_comb begin
      state_d    = state_q;
      clr_o      = 1'b0;
      load_o     = 1'b0;
      load_val_o = '0;
      dec_o      = 1'b0;
      if (pwrdn_i) begin
         state_d = ST_IDLE;
         clr_o   = 1'b1;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (est_i) begin
                  state_d    = ST_QUAL_ON;
                  load_o     = 1'b1;
                  load_val_o = ON_RELOAD;
               end
            end
            ST_QUAL_ON: begin
               if (!est_i) begin
                  state_d = ST_IDLE;
                  clr_o   = 1'b1;
               end else if (cnt_zero_i) begin
                  state_d = ST_HELD;
                  clr_o   = 1'b1;
               end else begin
                  dec_o = 1'b1;
               end
            end
            ST_HELD: begin
               if (!est_i) begin
                  state_d    = ST_QUAL_OFF;
                  load_o     = 1'b1;
                  load_val_o = OFF_RELOAD;
               end
            end
            ST_QUAL_OFF: begin
               if (est_i) begin
                  state_d = ST_HELD;
                  clr_o   = 1'b1;
               end else if (cnt_zero_i) begin
                  state_d = ST_IDLE;
                  clr_o   = 1'b1;
               end else begin
                  dec_o = 1'b1;
               end
            end
            default: begin
               state_d = ST_IDLE;
               clr_o   = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         rise_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         rise_q  <= (state_q == ST_QUAL_ON) && (state_d == ST_HELD);
      end
   end

   assign held_o = (state_q == ST_HELD) || (state_q == ST_QUAL_OFF);
   assign rise_o = rise_q;

endmodule

// File: rtl/tone_guard_validator.sv
`timescale 1ns/1ps
module tone_guard_validator
   import tgv_pkg::*;
#(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned PRESENT_CYCLES = 167772,
   parameter int unsigned ABSENT_CYCLES  = 83886
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic est_i,
   input  logic pwrdn_i,
   output logic steer_o,
   output logic rise_stb_o
);

   localparam int unsigned ON_W   = bits_for(PRESENT_CYCLES);
   localparam int unsigned OFF_W  = bits_for(ABSENT_CYCLES);
   localparam int unsigned CNT_W  = max_of(ON_W, OFF_W);
   localparam logic [CNT_W-1:0] ON_RELOAD  = CNT_W'(PRESENT_CYCLES - 2);
   localparam logic [CNT_W-1:0] OFF_RELOAD = CNT_W'(ABSENT_CYCLES - 2);

   if (PRESENT_CYCLES < 2) begin : g_bad_present
      $error("PRESENT_CYCLES must be at least 2");
   end
   if (ABSENT_CYCLES < 2) begin : g_bad_absent
      $error("ABSENT_CYCLES must be at least 2");
   end

   logic             est_sync;
   logic             cnt_clr;
   logic             cnt_load;
   logic [CNT_W-1:0] cnt_load_val;
   logic             cnt_dec;
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_zero;
   logic             held;
   logic             rise;

   if (SYNC_STAGES == 0) begin : g_no_sync
      assign est_sync = est_i;
   end else begin : g_sync
      tgv_sync #(
         .STAGES (SYNC_STAGES)
      ) i_sync (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .d_i    (est_i),
         .q_o    (est_sync)
      );
   end

   tgv_down_counter #(
      .WIDTH (CNT_W)
   ) i_counter (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (cnt_clr),
      .load_i     (cnt_load),
      .load_val_i (cnt_load_val),
      .dec_i      (cnt_dec),
      .cnt_o      (cnt_q),
      .zero_o     (cnt_zero)
   );

   tgv_guard_fsm #(
      .WIDTH      (CNT_W),
      .ON_RELOAD  (ON_RELOAD),
      .OFF_RELOAD (OFF_RELOAD)
   ) i_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pwrdn_i    (pwrdn_i),
      .est_i      (est_sync),
      .cnt_zero_i (cnt_zero),
      .clr_o      (cnt_clr),
      .load_o     (cnt_load),
      .load_val_o (cnt_load_val),
      .dec_o      (cnt_dec),
      .held_o     (held),
      .rise_o     (rise)
   );

   assign steer_o    = held & ~pwrdn_i;
   assign rise_stb_o = rise & ~pwrdn_i;

endmodule

// File: rtl/tgv_checker.sv
`timescale 1ns/1ps
module tgv_checker #(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned MAX_LOAD  = 0
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             pwrdn_i,
   input logic             est_sync,
   input logic             steer_o,
   input logic             rise_stb_o,
   input logic [CNT_W-1:0] cnt_q
);

   AST_PWRDN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwrdn_i |-> !steer_o); // R6

   AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_stb_o |=> !rise_stb_o); // R8

   AST_STB_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_stb_o |-> (steer_o && !$past(steer_o))); // R8

   AST_RISE_NEEDS_TONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(steer_o) |-> $past(est_sync)); // R2

   AST_FALL_NEEDS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(steer_o) && !pwrdn_i && !$past(pwrdn_i)) |-> !$past(est_sync)); // R4

   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_W'(MAX_LOAD)); // R9

endmodule

bind tone_guard_validator tgv_checker #(
   .CNT_W    (CNT_W),
   .MAX_LOAD (tgv_pkg::max_of(PRESENT_CYCLES, ABSENT_CYCLES) - 2)
) i_tgv_checker (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .pwrdn_i    (pwrdn_i),
   .est_sync   (est_sync),
   .steer_o    (steer_o),
   .rise_stb_o (rise_stb_o),
   .cnt_q      (cnt_q)
);

// File: tb/test_tone_guard_validator.sv
`timescale 1ns/1ps
module test_tone_guard_validator;

   localparam int unsigned S = 2;
   localparam int unsigned P = 6;
   localparam int unsigned A = 4;
   localparam int NV = 27;

   // Vector fields: [15] est, [14] pwrdn, [13:6] edges, [5] steer, [4] strobe, [3:0] requirement
   function automatic logic [15:0] mk(input logic e, input logic p, input int unsigned n,
                                      input logic d, input logic s, input int unsigned r);
      return {e, p, 8'(n), d, s, 4'(r)};
   endfunction

   localparam logic [15:0] VEC [NV] = '{
      mk(0,0,3,0,0,1),   // R1 idle after reset
      mk(1,0,7,0,0,2),   // R2 one edge short of presence
      mk(1,0,1,1,1,2),   // R2 rise at S+P, strobe
      mk(1,0,1,1,0,8),   // R8 strobe gone
      mk(0,0,5,1,0,4),   // R4 one edge short of absence
      mk(0,0,1,0,0,4),   // R4 fall at S+A
      mk(1,0,5,0,0,3),   // R3 short burst
      mk(0,0,1,0,0,3),   // R3 single low sample
      mk(1,0,7,0,0,3),   // R3 restart from zero
      mk(1,0,1,1,1,3),   // R3 rise after full fresh count
      mk(0,0,3,1,0,5),   // R5 dropout starts
      mk(1,0,1,1,0,5),   // R5 tone returns
      mk(0,0,2,1,0,8),   // R8 no strobe on return to held
      mk(0,0,3,1,0,5),   // R5 absence restarted
      mk(0,0,1,0,0,4),   // R4 fall
      mk(1,0,8,1,1,2),   // R2 rise again
      mk(1,1,1,0,0,6),   // R6 power-down while held
      mk(1,1,4,0,0,6),   // R6 stays low
      mk(1,0,5,0,0,7),   // R7 re-qualifying
      mk(1,0,1,1,1,7),   // R7 rise after P edges
      mk(0,0,3,1,0,5),   // R5 absence qualifying
      mk(0,1,1,0,0,6),   // R6 power-down during absence
      mk(0,0,10,0,0,6),  // R6 idle afterwards
      mk(1,0,5,0,0,3),   // R3 presence qualifying
      mk(1,1,2,0,0,6),   // R6 power-down during presence
      mk(1,0,5,0,0,7),   // R7 count restarted
      mk(1,0,1,1,1,7)    // R7 rise
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic est = 1'b0;
   logic pd = 1'b0;
   logic steer;
   logic stb;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tone_guard_validator #(
      .SYNC_STAGES    (S),
      .PRESENT_CYCLES (P),
      .ABSENT_CYCLES  (A)
   ) i_tone_guard_validator (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .est_i      (est),
      .pwrdn_i    (pd),
      .steer_o    (steer),
      .rise_stb_o (stb)
   );

   task automatic check(input logic got, input logic exp, input int unsigned req, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual %0b expected %0b at %0t", req, what, got, exp, $time);
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(steer, 1'b0, 1, "steer in reset");   // R1
      check(stb, 1'b0, 1, "strobe in reset");    // R1
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         est = VEC[i][15];
         pd  = VEC[i][14];
         repeat (int'(VEC[i][13:6])) @(posedge clk);
         @(negedge clk);
         check(steer, VEC[i][5], int'(VEC[i][3:0]), $sformatf("vector %0d steer", i));
         check(stb, VEC[i][4], int'(VEC[i][3:0]), $sformatf("vector %0d strobe", i));
      end

      // R6: power-down clears the output within the same cycle
      pd = 1'b1;
      #1;
      check(steer, 1'b0, 6, "combinational power-down");
      pd = 1'b0;
      #1;
      check(steer, 1'b1, 6, "release before any edge");

      // R1: asynchronous reset while held
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(steer, 1'b0, 1, "async reset while held");
      @(negedge clk);
      rst_n = 1'b1;
      est = 1'b1;
      repeat (S + P - 1) @(posedge clk);
      @(negedge clk);
      check(steer, 1'b0, 1, "reset cleared presence state");
      repeat (1) @(posedge clk);
      @(negedge clk);
      check(steer, 1'b1, 2, "rise after reset");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule